// File: doc/BRIEF.md
# Bus Write Buffer Pool

This block holds the outgoing write traffic of a bus interface unit until the system bus takes it. It has three kinds of storage. One dedicated burst slot takes snoop pushes of modified lines. A queue of three burst entries takes cache castouts, block-flush writes and block-clean writes. A queue of two single-beat entries takes stores of up to eight bytes. Each burst entry holds one 32-byte block, sent as four 64-bit beats.

The block drains one entry at a time through a request/grant/acknowledge port. When it is idle, it picks the snoop slot first, then the oldest copy-back, then the oldest single-beat store. It raises a request and holds the address and kind until a grant arrives. It then presents the beats one by one, and each beat advances on an acknowledge. The entry is freed on the acknowledge of its last beat.

Each accepted snoop push raises a load/store stall for exactly one cycle. This covers the cycle in which the block is copied into the slot. Upstream producers watch the full and ready outputs and wait while these show the storage as occupied.

Top module: `wbuf_pool`

## Requirements
- R1: A snoop push is accepted only while `snp_ready` is high, which means the dedicated snoop slot is empty. A push offered while the slot is occupied is ignored and produces no bus tenure.
- R2: `lsu_stall` is high for exactly one cycle, in the cycle after a snoop push is accepted, and is low at all other times.
- R3: Copy-back requests are queued in up to three entries. `cb_kind` 0 (castout), 1 (flush) and 2 (clean) appear on `bus_kind` as 1, 2 and 3.
- R4: `cb_full` is high while three copy-backs are held. A copy-back request offered while full is ignored. `cb_full` stays high until the last beat of a copy-back is acknowledged.
- R5: Single-beat stores are queued in up to two entries, and `sb_full` is high when both are held. A store drains as one beat with `bus_kind` 4, `bus_burst` low and `bus_be` equal to the store's byte enables.
- R6: When the drain engine starts a new tenure, it picks the snoop slot first, then the oldest copy-back, then the oldest single-beat store. A tenure already requested is not preempted.
- R7: `bus_req` stays high with a stable `bus_addr` and `bus_kind` until `bus_grant`. `bus_dval` rises in the cycle after the grant, and `bus_req` and `bus_dval` are never high together.
- R8: A burst tenure has `bus_burst` high, `bus_be` all ones and four beats. Beat n carries bits [64n+63:64n] of the block. Each beat is held until `bus_ack`.
- R9: An entry is freed by the acknowledge of its final beat. In the following cycle its slot can accept a new entry, shown by `snp_ready` rising or `cb_full` falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snp_push_valid | input | 1 | Snoop push of a modified line offered |
| snp_push_addr | input | 32 | Block address of the snoop push |
| snp_push_data | input | 256 | Block data of the snoop push |
| snp_ready | output | 1 | Snoop slot empty, a push is accepted |
| lsu_stall | output | 1 | One-cycle load/store stall after a snoop push |
| cb_valid | input | 1 | Copy-back request offered |
| cb_kind | input | 2 | 0 castout, 1 flush, 2 clean |
| cb_addr | input | 32 | Block address of the copy-back |
| cb_data | input | 256 | Block data of the copy-back |
| cb_full | output | 1 | All copy-back entries occupied |
| sb_valid | input | 1 | Single-beat store offered |
| sb_addr | input | 32 | Store address |
| sb_data | input | 64 | Store data |
| sb_be | input | 8 | Store byte enables |
| sb_full | output | 1 | Both single-beat entries occupied |
| bus_req | output | 1 | Write tenure requested |
| bus_grant | input | 1 | Grant of the requested tenure |
| bus_addr | output | 32 | Address of the tenure |
| bus_kind | output | 3 | 0 snoop push, 1 castout, 2 flush, 3 clean, 4 single store |
| bus_burst | output | 1 | Tenure is a four-beat burst |
| bus_be | output | 8 | Byte enables of the tenure |
| bus_dval | output | 1 | Data beat valid |
| bus_data | output | 64 | Data beat |
| bus_ack | input | 1 | Acknowledge of the current beat |

## Verification
The hardest case to reach is a pool with every kind of storage occupied at once while a lower-priority tenure is already pending. This is the only state in which the ordering rule and the no-preemption rule both matter. The bench loads two stores first so that the engine commits to a store. It then fills all three copy-back entries, pushes a snoop and withholds the grant. The drain order it observes must then be store, snoop, copy-backs oldest first, and the remaining store. Rejected requests are offered into the full queue and the busy snoop slot, and the bench confirms that no extra tenure follows. A sweep over rotated copy-back kinds with varying acknowledge gaps covers the kind mapping and beat holding.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
  typedef enum logic [2:0] {
    KIND_SNOOP   = 3'd0,
    KIND_CASTOUT = 3'd1,
    KIND_FLUSH   = 3'd2,
    KIND_CLEAN   = 3'd3,
    KIND_SINGLE  = 3'd4
  } wr_kind_e;

  typedef enum logic [1:0] {
    SRC_SNP,
    SRC_CB,
    SRC_SB
  } src_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_DATA
  } drain_st_e;
endpackage

// File: rtl/wbp_fifo.sv
module wbp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 3,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         has
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = mem[rd_ptr];
  assign full = (count == CW'(DEPTH));
  assign has  = (count != '0);
endmodule

// File: rtl/wbp_snoop_slot.sv
module wbp_snoop_slot #(
  parameter int AW  = 32,
  parameter int BLK = 256
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push_valid,
  input  logic [AW-1:0]  push_addr,
  input  logic [BLK-1:0] push_blk,
  input  logic           pop,
  output logic           ready,
  output logic           has,
  output logic [AW-1:0]  addr_q,
  output logic [BLK-1:0] blk_q,
  output logic           stall
);
  logic valid_q;
  logic take;

  assign take  = push_valid && !valid_q;
  assign ready = !valid_q;
  assign has   = valid_q;

  always_ff @(posedge clk) begin
    if (take) begin
      addr_q <= push_addr;
      blk_q  <= push_blk;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      stall   <= 1'b0;
    end else begin
      stall <= take;
      if (take)     valid_q <= 1'b1;
      else if (pop) valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wbp_drain.sv
module wbp_drain
  import wbp_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int BEATS = 4,
  localparam int BLK  = DW * BEATS,
  localparam int BEW  = DW / 8,
  localparam int BW   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           snp_has,
  input  logic [AW-1:0]  snp_addr,
  input  logic [BLK-1:0] snp_blk,
  input  logic           cb_has,
  input  logic [AW-1:0]  cb_addr,
  input  logic [1:0]     cb_kind,
  input  logic [BLK-1:0] cb_blk,
  input  logic           sb_has,
  input  logic [AW-1:0]  sb_addr,
  input  logic [DW-1:0]  sb_data,
  input  logic [BEW-1:0] sb_be,
  input  logic           bus_grant,
  input  logic           bus_ack,
  output logic           bus_req,
  output logic [AW-1:0]  bus_addr,
  output logic [2:0]     bus_kind,
  output logic           bus_burst,
  output logic [BEW-1:0] bus_be,
  output logic           bus_dval,
  output logic [DW-1:0]  bus_data,
  output logic           pop_snp,
  output logic           pop_cb,
  output logic           pop_sb
);
  drain_st_e      st_q;
  src_e           src_q;
  logic [BW-1:0]  beat_q;
  logic [BLK-1:0] sel_blk;
  logic [BW-1:0]  nxt_idx;
  logic [BW-1:0]  last_beat;
  logic [DW-1:0]  nxt_data;
  logic           fin;

  always_comb begin
    case (src_q)
      SRC_SNP: sel_blk = snp_blk;
      SRC_CB:  sel_blk = cb_blk;
      default: sel_blk = BLK'(sb_data);
    endcase
    nxt_idx   = (st_q == ST_REQ) ? '0 : beat_q + 1'b1;
    nxt_data  = sel_blk[int'(nxt_idx) * DW +: DW];
    last_beat = bus_burst ? BW'(BEATS - 1) : '0;
    fin       = (st_q == ST_DATA) && bus_ack && (beat_q == last_beat);
  end

  assign pop_snp = fin && (src_q == SRC_SNP);
  assign pop_cb  = fin && (src_q == SRC_CB);
  assign pop_sb  = fin && (src_q == SRC_SB);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      src_q     <= SRC_SNP;
      beat_q    <= '0;
      bus_req   <= 1'b0;
      bus_dval  <= 1'b0;
      bus_addr  <= '0;
      bus_kind  <= 3'd0;
      bus_burst <= 1'b0;
      bus_be    <= '0;
      bus_data  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (snp_has) begin
            src_q     <= SRC_SNP;
            bus_addr  <= snp_addr;
            bus_kind  <= KIND_SNOOP;
            bus_burst <= 1'b1;
            bus_be    <= '1;
          end else if (cb_has) begin
            src_q     <= SRC_CB;
            bus_addr  <= cb_addr;
            bus_kind  <= 3'(cb_kind) + 3'd1;
            bus_burst <= 1'b1;
            bus_be    <= '1;
          end else begin
            src_q     <= SRC_SB;
            bus_addr  <= sb_addr;
            bus_kind  <= KIND_SINGLE;
            bus_burst <= 1'b0;
            bus_be    <= sb_be;
          end
          if (snp_has || cb_has || sb_has) begin
            st_q    <= ST_REQ;
            bus_req <= 1'b1;
          end
        end
        ST_REQ: begin
          if (bus_grant) begin
            st_q     <= ST_DATA;
            bus_req  <= 1'b0;
            bus_dval <= 1'b1;
            beat_q   <= '0;
            bus_data <= nxt_data;
          end
        end
        default: begin
          if (bus_ack) begin
            if (fin) begin
              st_q     <= ST_IDLE;
              bus_dval <= 1'b0;
            end else begin
              beat_q   <= beat_q + 1'b1;
              bus_data <= nxt_data;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/wbuf_pool.sv
module wbuf_pool #(
  parameter int AW       = 32,
  parameter int DW       = 64,
  parameter int BEATS    = 4,
  parameter int CB_DEPTH = 3,
  parameter int SB_DEPTH = 2,
  localparam int BLK     = DW * BEATS,
  localparam int BEW     = DW / 8,
  localparam int CB_W    = 2 + AW + BLK,
  localparam int SB_W    = AW + DW + BEW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           snp_push_valid,
  input  logic [AW-1:0]  snp_push_addr,
  input  logic [BLK-1:0] snp_push_data,
  output logic           snp_ready,
  output logic           lsu_stall,
  input  logic           cb_valid,
  input  logic [1:0]     cb_kind,
  input  logic [AW-1:0]  cb_addr,
  input  logic [BLK-1:0] cb_data,
  output logic           cb_full,
  input  logic           sb_valid,
  input  logic [AW-1:0]  sb_addr,
  input  logic [DW-1:0]  sb_data,
  input  logic [BEW-1:0] sb_be,
  output logic           sb_full,
  output logic           bus_req,
  input  logic           bus_grant,
  output logic [AW-1:0]  bus_addr,
  output logic [2:0]     bus_kind,
  output logic           bus_burst,
  output logic [BEW-1:0] bus_be,
  output logic           bus_dval,
  output logic [DW-1:0]  bus_data,
  input  logic           bus_ack
);
  logic           snp_has, cb_has, sb_has;
  logic           pop_snp, pop_cb, pop_sb;
  logic [AW-1:0]  snp_addr_q;
  logic [BLK-1:0] snp_blk_q;
  logic [CB_W-1:0] cb_head;
  logic [SB_W-1:0] sb_head;

  wbp_snoop_slot #(.AW(AW), .BLK(BLK)) snoop_i (
    .clk(clk), .rst(rst),
    .push_valid(snp_push_valid), .push_addr(snp_push_addr), .push_blk(snp_push_data),
    .pop(pop_snp), .ready(snp_ready), .has(snp_has),
    .addr_q(snp_addr_q), .blk_q(snp_blk_q), .stall(lsu_stall)
  );

  wbp_fifo #(.W(CB_W), .DEPTH(CB_DEPTH)) cbq_i (
    .clk(clk), .rst(rst),
    .push(cb_valid && !cb_full), .wdata({cb_kind, cb_addr, cb_data}),
    .pop(pop_cb), .head(cb_head), .full(cb_full), .has(cb_has)
  );

  wbp_fifo #(.W(SB_W), .DEPTH(SB_DEPTH)) sbq_i (
    .clk(clk), .rst(rst),
    .push(sb_valid && !sb_full), .wdata({sb_addr, sb_data, sb_be}),
    .pop(pop_sb), .head(sb_head), .full(sb_full), .has(sb_has)
  );

  wbp_drain #(.AW(AW), .DW(DW), .BEATS(BEATS)) drain_i (
    .clk(clk), .rst(rst),
    .snp_has(snp_has), .snp_addr(snp_addr_q), .snp_blk(snp_blk_q),
    .cb_has(cb_has), .cb_addr(cb_head[BLK +: AW]), .cb_kind(cb_head[CB_W-1 -: 2]),
    .cb_blk(cb_head[BLK-1:0]),
    .sb_has(sb_has), .sb_addr(sb_head[SB_W-1 -: AW]), .sb_data(sb_head[BEW +: DW]),
    .sb_be(sb_head[BEW-1:0]),
    .bus_grant(bus_grant), .bus_ack(bus_ack),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_kind(bus_kind), .bus_burst(bus_burst),
    .bus_be(bus_be), .bus_dval(bus_dval), .bus_data(bus_data),
    .pop_snp(pop_snp), .pop_cb(pop_cb), .pop_sb(pop_sb)
  );
endmodule

// File: rtl/wbuf_pool_chk.sv
module wbuf_pool_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          snp_push_valid,
  input logic          snp_ready,
  input logic          lsu_stall,
  input logic          cb_full,
  input logic          bus_req,
  input logic          bus_grant,
  input logic          bus_ack,
  input logic          bus_dval,
  input logic [AW-1:0] bus_addr,
  input logic [2:0]    bus_kind
);
  assert_stall_after_push_R2: assert property (@(posedge clk) disable iff (rst)
    (snp_push_valid && snp_ready) |=> lsu_stall);

  assert_stall_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    lsu_stall |=> !lsu_stall);

  assert_full_until_ack_R4: assert property (@(posedge clk) disable iff (rst)
    (cb_full && !bus_ack) |=> cb_full);

  assert_snoop_first_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_req) && !$past(snp_ready) && !$past(bus_ack)) |-> (bus_kind == 3'd0));

  assert_req_held_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_grant) |=> (bus_req && $stable(bus_addr) && $stable(bus_kind)));

  assert_dval_after_grant_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_dval) |-> $past(bus_grant));

  assert_req_dval_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && bus_dval));
endmodule

bind wbuf_pool wbuf_pool_chk #(.AW(AW)) chk_i (.*);

// File: tb/wbuf_pool_tb_top.sv
`timescale 1ns/1ps
module wbuf_pool_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         snp_push_valid = 1'b0;
  logic [31:0]  snp_push_addr = '0;
  logic [255:0] snp_push_data = '0;
  logic         snp_ready, lsu_stall;
  logic         cb_valid = 1'b0;
  logic [1:0]   cb_kind = '0;
  logic [31:0]  cb_addr = '0;
  logic [255:0] cb_data = '0;
  logic         cb_full;
  logic         sb_valid = 1'b0;
  logic [31:0]  sb_addr = '0;
  logic [63:0]  sb_data = '0;
  logic [7:0]   sb_be = '0;
  logic         sb_full;
  logic         bus_req, bus_burst, bus_dval;
  logic         bus_grant = 1'b0;
  logic         bus_ack = 1'b0;
  logic [31:0]  bus_addr;
  logic [2:0]   bus_kind;
  logic [7:0]   bus_be;
  logic [63:0]  bus_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wbuf_pool dut_i (.*);

  function automatic logic [63:0] pat(input logic [31:0] a, input int b);
    return {a ^ 32'h0F0F_0000, 32'h5A00_0000 | 32'(b)};
  endfunction

  function automatic logic [255:0] blk(input logic [31:0] a);
    return {pat(a, 3), pat(a, 2), pat(a, 1), pat(a, 0)};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic push_cb(input logic [31:0] a, input logic [1:0] k);
    cb_valid = 1'b1; cb_addr = a; cb_kind = k; cb_data = blk(a);
    @(negedge clk);
    cb_valid = 1'b0;
  endtask

  task automatic push_sb(input logic [31:0] a, input logic [7:0] be);
    sb_valid = 1'b1; sb_addr = a; sb_data = pat(a, 0); sb_be = be;
    @(negedge clk);
    sb_valid = 1'b0;
  endtask

  task automatic drain_one(input logic [2:0] ek, input logic [31:0] ea,
                           input logic [7:0] ebe, input int gap);
    int w = 0;
    int nb;
    while (!bus_req && w < 100) begin @(negedge clk); w++; end
    chk(bus_req, "R7", "request raised", 64'(bus_req), 64'd1);
    chk(bus_kind == ek, "R6", "tenure kind", 64'(bus_kind), 64'(ek));
    chk(bus_addr == ea, "R6", "tenure address", 64'(bus_addr), 64'(ea));
    chk(bus_burst == (ek != 3'd4), "R8", "burst flag", 64'(bus_burst), 64'(ek != 3'd4));
    chk(bus_be == ebe, "R5", "byte enables", 64'(bus_be), 64'(ebe));
    @(negedge clk);
    chk(bus_req && bus_addr == ea && !bus_dval, "R7", "request held without grant",
        64'(bus_addr), 64'(ea));
    bus_grant = 1'b1;
    @(negedge clk);
    bus_grant = 1'b0;
    nb = (ek == 3'd4) ? 1 : 4;
    for (int b = 0; b < nb; b++) begin
      chk(bus_dval && !bus_req, "R7", "beat valid after grant", 64'(bus_dval), 64'd1);
      chk(bus_data == pat(ea, b), "R8", "beat data", bus_data, pat(ea, b));
      if (gap > 0) begin
        repeat (gap) @(negedge clk);
        chk(bus_data == pat(ea, b), "R8", "beat held until ack", bus_data, pat(ea, b));
      end
      bus_ack = 1'b1;
      @(negedge clk);
      bus_ack = 1'b0;
    end
    chk(!bus_dval, "R8", "tenure ended after last beat", 64'(bus_dval), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_req && !bus_dval, "R7", "reset bus idle", 64'(bus_req), 64'd0);
    chk(!cb_full && !sb_full, "R4", "reset not full", 64'({cb_full, sb_full}), 64'd0);
    chk(snp_ready && !lsu_stall, "R1", "reset snoop slot empty", 64'(snp_ready), 64'd1);

    // Full pool: two stores, three copy-backs, one snoop push.
    push_sb(32'h0000_0100, 8'h0F);
    push_sb(32'h0000_0108, 8'hF0);
    chk(sb_full, "R5", "two stores fill queue", 64'(sb_full), 64'd1);
    push_cb(32'h0000_1000, 2'd0);
    push_cb(32'h0000_2000, 2'd1);
    push_cb(32'h0000_3000, 2'd2);
    chk(cb_full, "R4", "three copy-backs fill queue", 64'(cb_full), 64'd1);
    cb_valid = 1'b1; cb_addr = 32'h0000_4000; cb_kind = 2'd0; cb_data = blk(32'h0000_4000);
    repeat (3) begin
      @(negedge clk);
      chk(cb_full, "R4", "full held under rejected request", 64'(cb_full), 64'd1);
    end
    cb_valid = 1'b0;

    chk(snp_ready, "R1", "snoop slot ready", 64'(snp_ready), 64'd1);
    snp_push_valid = 1'b1; snp_push_addr = 32'h0000_5000; snp_push_data = blk(32'h0000_5000);
    @(negedge clk);
    snp_push_valid = 1'b0;
    chk(lsu_stall, "R2", "stall after snoop push", 64'(lsu_stall), 64'd1);
    chk(!snp_ready, "R1", "snoop slot occupied", 64'(snp_ready), 64'd0);
    @(negedge clk);
    chk(!lsu_stall, "R2", "stall lasts one cycle", 64'(lsu_stall), 64'd0);
    snp_push_valid = 1'b1; snp_push_addr = 32'h0000_6000; snp_push_data = blk(32'h0000_6000);
    @(negedge clk);
    snp_push_valid = 1'b0;
    chk(!lsu_stall, "R1", "busy slot rejects push", 64'(lsu_stall), 64'd0);

    drain_one(3'd4, 32'h0000_0100, 8'h0F, 0);
    drain_one(3'd0, 32'h0000_5000, 8'hFF, 1);
    chk(snp_ready, "R9", "snoop slot freed", 64'(snp_ready), 64'd1);
    chk(cb_full, "R4", "full before last copy-back ack", 64'(cb_full), 64'd1);
    drain_one(3'd1, 32'h0000_1000, 8'hFF, 2);
    chk(!cb_full, "R9", "copy-back entry freed", 64'(cb_full), 64'd0);
    drain_one(3'd2, 32'h0000_2000, 8'hFF, 0);
    drain_one(3'd3, 32'h0000_3000, 8'hFF, 0);
    drain_one(3'd4, 32'h0000_0108, 8'hF0, 0);
    repeat (6) begin
      @(negedge clk);
      chk(!bus_req, "R4", "rejected requests left no tenure (R1)", 64'(bus_req), 64'd0);
    end

    // Sweep of copy-back kind rotations and acknowledge gaps.
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 3; i++)
        push_cb(32'h0000_8000 + 32'(r * 256 + i * 32), 2'((r + i) % 3));
      for (int i = 0; i < 3; i++)
        drain_one(3'((r + i) % 3 + 1), 32'h0000_8000 + 32'(r * 256 + i * 32), 8'hFF, r);
      chk(!cb_full, "R3", "queue empty after sweep step", 64'(cb_full), 64'd0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule